// File: doc/BRIEF.md
# Rate-Selected Symbol Stream Demultiplexer

This block sits between channel equalization and the demodulation paths of an OFDM receiver. It takes one valid/ready stream of equalized symbol words and steers each symbol to one of five valid/ready output paths. Path 0 carries the signal/header field. Paths 1 to 4 each carry payload for one modulation group. A symbol is a run of words that closes with a word flagged by `in_last`. The path is chosen when the first word of a symbol is presented and is held until that symbol's last word has been accepted.

Routing depends on two inputs. The first is a header-busy indication from the header parser. The second is the current data rate, given in kbps. While the header is still being decoded, symbols go to path 0. After that, the rate selects a payload path. If the rate is not one of the eight legal values, the block accepts the symbol words and discards them, and it flags each discarded word.

At the end of each frame, a strobe makes the block issue one-cycle reset pulses. The header path always gets a pulse. A payload path gets one only if it is the path the current rate selects. Data and last flag are carried on one shared output bus. Only the valid signal of the chosen path is raised.

Top module: `rsd_stream_demux`

## Requirements
- R1: When a symbol starts while `hdr_busy` is 1, all its words go to path 0 whatever `rate_kbps` holds.
- R2: When a symbol starts while `hdr_busy` is 0, the rate selects its path: 6000 or 9000 selects path 1, 12000 or 18000 selects path 2, 24000 or 36000 selects path 3, and 48000 or 54000 selects path 4.
- R3: The path is chosen at the first word of a symbol and is kept for every later word up to and including the word with `in_last` = 1. Changes on `rate_kbps` or `hdr_busy` in between do not move the remaining words.
- R4: Only the selected path's bit of `out_valid` follows `in_valid`, and `out_valid` is at most one-hot. `in_ready` equals the selected path's `out_ready` bit, and the other `out_ready` bits have no effect. `out_data` and `out_last` equal `in_data` and `in_last`.
- R5: A payload symbol with an illegal rate is accepted (`in_ready` = 1) with no `out_valid` bit raised. `rate_err` is 1 in the cycle after each such discarded word and is 0 otherwise.
- R6: A cycle with `frame_end` = 1 makes `path_rst` in the following cycle hold bit 0 plus the bit of the path the current `rate_kbps` selects. Every other cycle `path_rst` is 0.
- R7: If `rate_kbps` is illegal when `frame_end` is 1, only bit 0 of `path_rst` pulses.
- R8: While reset is held and in the first cycle after it, `path_rst` and `rate_err` are 0, and the block is at a symbol boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | DATA_W | Input symbol word |
| in_last | input | 1 | Last word of the current symbol |
| hdr_busy | input | 1 | Header field still being decoded |
| rate_kbps | input | RATE_W | Payload data rate in kbps |
| frame_end | input | 1 | End-of-frame strobe |
| out_valid | output | 5 | Per-path word valid, bit n for path n |
| out_ready | input | 5 | Per-path ready, bit n for path n |
| out_data | output | DATA_W | Shared output word |
| out_last | output | 1 | Shared last-word flag |
| path_rst | output | 5 | Per-path one-cycle reset pulse |
| rate_err | output | 1 | Pulse after each discarded word |

## Verification
`out_valid`, `in_ready`, `out_data` and `out_last` are combinational, so they are due in the same cycle as the input that causes them. `path_rst` and `rate_err` come from one register and are due exactly one cycle after the `frame_end` strobe or the discarded handshake. The bench drives inputs at the falling edge and compares all outputs against its reference model one time step later. The model commits its next-state values, which include the pending reset and error pulses, at the rising edge, so each registered result is compared in the cycle after its cause.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  localparam int NPATH = 5;
  localparam int SEL_W = 3;
  typedef logic [SEL_W-1:0] sel_t;
  localparam sel_t SEL_HDR  = 3'd0;
  localparam sel_t SEL_DROP = 3'd7;

  // Map a data rate in kbps to its payload path; SEL_DROP for an illegal rate.
  function automatic sel_t rate_path(input int unsigned kbps);
    case (kbps)
      6000,  9000:  rate_path = 3'd1;
      12000, 18000: rate_path = 3'd2;
      24000, 36000: rate_path = 3'd3;
      48000, 54000: rate_path = 3'd4;
      default:      rate_path = SEL_DROP;
    endcase
  endfunction

  // Path for a symbol that starts now.
  function automatic sel_t start_path(input logic hdr, input int unsigned kbps);
    start_path = hdr ? SEL_HDR : rate_path(kbps);
  endfunction
endpackage

// File: rtl/rsd_symbol_track.sv
module rsd_symbol_track
  import rsd_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_busy,
  input  logic [RATE_W-1:0] rate_kbps,
  input  logic              in_fire,
  input  logic              in_last,
  output sel_t              cur_sel,
  output logic              mid_sym
);
  sel_t held_q;
  logic mid_q;
  sel_t fresh_sel;

  assign fresh_sel = start_path(hdr_busy, 32'(rate_kbps));
  assign cur_sel   = mid_q ? held_q : fresh_sel;
  assign mid_sym   = mid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid_q  <= 1'b0;
      held_q <= SEL_HDR;
    end else if (in_fire) begin
      mid_q  <= !in_last;
      held_q <= cur_sel;
    end
  end

  p_hold_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !in_last) |=> (cur_sel == $past(cur_sel)));

  p_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_last) |=> !mid_sym);
endmodule

// File: rtl/rsd_reset_gen.sv
module rsd_reset_gen
  import rsd_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [RATE_W-1:0] rate_kbps,
  output logic [NPATH-1:0]  path_rst
);
  sel_t rate_sel;
  logic [NPATH-1:0] rst_q;

  assign rate_sel = rate_path(32'(rate_kbps));
  assign path_rst = rst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rst_q[0] <= 1'b0;
    else        rst_q[0] <= frame_end;
  end

  for (genvar i = 1; i < NPATH; i++) begin : g_payload_rst
    always_ff @(posedge clk) begin
      if (!rst_n) rst_q[i] <= 1'b0;
      else        rst_q[i] <= frame_end && (rate_sel == sel_t'(i));
    end
  end

  p_hdr_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> path_rst[0]);

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> (path_rst == '0));

  p_one_payload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(path_rst[NPATH-1:1]) <= 1);
endmodule

// File: rtl/rsd_port_fanout.sv
module rsd_port_fanout
  import rsd_pkg::*;
(
  input  logic             in_valid,
  input  sel_t             sel,
  input  logic [NPATH-1:0] out_ready,
  output logic [NPATH-1:0] out_valid,
  output logic             in_ready,
  output logic             drop
);
  logic [NPATH-1:0] hit;

  for (genvar i = 0; i < NPATH; i++) begin : g_port
    assign hit[i]       = (sel == sel_t'(i));
    assign out_valid[i] = in_valid && hit[i];
  end

  assign drop     = (sel == SEL_DROP);
  assign in_ready = drop || (|(hit & out_ready));
endmodule

// File: rtl/rsd_stream_demux.sv
module rsd_stream_demux
  import rsd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              hdr_busy,
  input  logic [RATE_W-1:0] rate_kbps,
  input  logic              frame_end,
  output logic [4:0]        out_valid,
  input  logic [4:0]        out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [4:0]        path_rst,
  output logic              rate_err
);
  sel_t cur_sel;
  logic mid_sym;
  logic in_fire;
  logic drop;
  logic err_q;

  assign in_fire  = in_valid && in_ready;
  assign out_data = in_data;
  assign out_last = in_last;
  assign rate_err = err_q;

  rsd_symbol_track #(.RATE_W(RATE_W)) u_track (
    .clk(clk), .rst_n(rst_n), .hdr_busy(hdr_busy), .rate_kbps(rate_kbps),
    .in_fire(in_fire), .in_last(in_last), .cur_sel(cur_sel), .mid_sym(mid_sym)
  );

  rsd_port_fanout u_fan (
    .in_valid(in_valid), .sel(cur_sel), .out_ready(out_ready),
    .out_valid(out_valid), .in_ready(in_ready), .drop(drop)
  );

  rsd_reset_gen #(.RATE_W(RATE_W)) u_rst (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .rate_kbps(rate_kbps),
    .path_rst(path_rst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= in_valid && drop;
  end

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  p_out_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & out_ready)) |-> in_fire);

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && drop) |-> (in_ready && out_valid == '0));

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && drop) |=> rate_err);

  p_hdr_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mid_sym && hdr_busy && in_valid) |-> out_valid[0]);
endmodule

// File: tb/tb_rsd_stream_demux.sv
`timescale 1ns/1ps
module tb_rsd_stream_demux;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        in_last;
  logic        hdr_busy;
  logic [15:0] rate_kbps;
  logic        frame_end;
  logic [4:0]  out_valid;
  logic [4:0]  out_ready;
  logic [31:0] out_data;
  logic        out_last;
  logic [4:0]  path_rst;
  logic        rate_err;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rsd_stream_demux dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .hdr_busy(hdr_busy),
    .rate_kbps(rate_kbps), .frame_end(frame_end), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .path_rst(path_rst), .rate_err(rate_err)
  );

  // Reference model state
  int  legal[8] = '{6000, 9000, 12000, 18000, 24000, 36000, 48000, 54000};
  bit  m_mid = 0;
  int  m_held = 0;
  bit  m_err = 0;
  int  m_rst = 0;

  function automatic int model_path(int kbps);
    for (int k = 0; k < 8; k++) if (legal[k] == kbps) return k / 2 + 1;
    return -1;
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, compare, then advance model at rising edge.
  task automatic cyc(bit v, bit last, bit hb, int rate, bit fe, int rdy);
    int p;
    int e_valid;
    int e_ready;
    @(negedge clk);
    in_valid = v; in_last = last; hdr_busy = hb; rate_kbps = 16'(rate);
    frame_end = fe; out_ready = 5'(rdy); in_data = $urandom;
    #1;
    p = m_mid ? m_held : (hb ? 0 : model_path(rate));
    e_valid = (v && p >= 0) ? (1 << p) : 0;
    e_ready = (p < 0) ? 1 : ((rdy >> p) & 1);
    check(hb && !m_mid ? "R1 out_valid" : (m_mid ? "R3 out_valid" : "R2 out_valid"),
          int'(out_valid), e_valid);
    check("R4 in_ready", int'(in_ready), e_ready);
    check("R4 out_data", int'(out_data), int'(in_data));
    check("R4 out_last", int'(out_last), int'(last));
    check("R5 rate_err", int'(rate_err), int'(m_err));
    check(m_rst == 1 ? "R7 path_rst" : "R6 path_rst", int'(path_rst), m_rst);
    @(posedge clk);
    if (v && e_ready == 1) begin
      m_held = p;
      m_mid  = !last;
    end
    m_err = v && (p < 0);
    if (fe) m_rst = 1 | ((model_path(rate) > 0) ? (1 << model_path(rate)) : 0);
    else    m_rst = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_last = 0; hdr_busy = 0; rate_kbps = 0;
    frame_end = 0; out_ready = 0; in_data = 0;
    repeat (3) @(negedge clk);
    frame_end = 1;
    #1;
    check("R8 path_rst", int'(path_rst), 0);
    check("R8 rate_err", int'(rate_err), 0);
    @(negedge clk);
    frame_end = 0;
    #1;
    check("R8 path_rst", int'(path_rst), 0);
    rst_n = 1;
    // R8 first symbol after reset starts fresh; R1 header symbol of 3 words
    cyc(1, 0, 1, 54000, 0, 5'h1f);
    cyc(1, 0, 0, 6000,  0, 5'h1f);
    cyc(1, 1, 0, 6000,  0, 5'h1f);
    // R2 every legal rate, single-word symbols
    foreach (legal[k]) cyc(1, 1, 0, legal[k], 0, 5'h1f);
    // R3 rate and header change mid-symbol
    cyc(1, 0, 0, 12000, 0, 5'h1f);
    cyc(1, 0, 1, 48000, 0, 5'h1f);
    cyc(1, 0, 0, 7000,  0, 5'h1f);
    cyc(1, 1, 0, 9000,  0, 5'h1f);
    // R4 back-pressure on selected path, other readies toggling
    cyc(1, 0, 0, 24000, 0, 5'h17);
    cyc(1, 0, 0, 24000, 0, 5'h08);
    cyc(1, 1, 0, 6000,  0, 5'h00);
    cyc(1, 1, 0, 6000,  0, 5'h08);
    // R5 illegal rate drops, including an idle gap
    cyc(1, 0, 0, 5000,  0, 5'h00);
    cyc(0, 0, 0, 5000,  0, 5'h00);
    cyc(1, 1, 0, 54000, 0, 5'h00);
    cyc(0, 0, 0, 54000, 0, 5'h1f);
    // R6 and R7 frame-end pulses
    foreach (legal[k]) cyc(0, 0, 0, legal[k], 1, 5'h1f);
    cyc(0, 0, 0, 11000, 1, 5'h1f);
    cyc(0, 0, 0, 11000, 0, 5'h1f);
    cyc(1, 1, 1, 0,     1, 5'h1f);
    cyc(0, 0, 0, 0,     0, 5'h1f);
    // Mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      int sel;
      sel = $urandom_range(0, 9);
      r = (sel < 8) ? legal[sel] : ((sel == 8) ? 3000 : 60000);
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0,
          $urandom_range(0, 3) == 0, r, $urandom_range(0, 7) == 0,
          int'($urandom_range(0, 31)));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule